// File: doc/BRIEF.md
# I2C Enable, Abort and Command-Hold Controller

This block owns the software-facing enable, abort and command-hold controls of an I2C controller and turns them into the internal signals the rest of the controller obeys. Software writes a three-bit control word through a single write strobe. The block passes the enable through a short synchronizing pipeline into the bus-side clock domain and drives an internal core enable. It also drives the FIFO flush and a graceful-stop request to the bus engines, and a start permission for queued master commands. Once the master sequencer reports that its STOP and transmit flush are complete, the block retires the abort and raises a one-cycle user-abort event.

Shutdown is graceful. After a disable is written, the core enable stays high until both the master and the slave state machines report idle. Software can therefore poll the core enable to learn when shutdown is complete. If the disable lands while a remote master is addressing this device, or while it is sending data to it, sticky status flags record this. Software reads them after the disable, and the next enable clears them. The block also registers per-engine activity bits and their combined activity status.

Top module: `i2c_enable_ctrl`

## Requirements
- R1: After reset, en_bit, abort_bit, block_bit, core_en, disable_req, user_abort, the slave status flags and the activity bits are 0, and fifo_flush is 1.
- R2: A write with sw_abort=1 sets abort_bit only if en_bit was already 1 before that write. A write that sets sw_en and sw_abort together from the disabled state leaves abort_bit at 0.
- R3: Writes cannot clear abort_bit. It clears at the clock edge that samples abort_done=1, and user_abort is 1 for exactly the one cycle after that edge.
- R4: en_bit follows sw_en at the edge that captures the write. core_en rises two clock edges after that edge.
- R5: After a disabling write, disable_req is 1 from the second edge onward while core_en is still 1. core_en falls at the first edge from the second onward at which mst_idle and slv_idle are both 1.
- R6: fifo_flush rises one edge after the write edge of a disabling write, and falls one edge after the write edge of an enabling write.
- R7: slv_dis_busy sets at any edge that samples disable_req=1 together with slv_rx_busy=1 (slave receiving an address or data byte), and holds until it is cleared as R9 states.
- R8: slv_data_lost sets at any edge that samples disable_req=1 together with slv_rx_data=1 (addressed slave receive in its data phase). It stays 0 if only slv_rx_busy was 1.
- R9: Both slave status flags clear at the edge where core_en rises.
- R10: cmd_start_ok is 1 only while core_en=1, no disable is pending, block_bit=0 and tx_nempty=1. block_bit follows sw_block at the write edge.
- R11: mst_act and slv_act equal the inverse of mst_idle and slv_idle delayed by one edge, and activity is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Control-word write strobe |
| sw_en | input | 1 | Write data: enable |
| sw_abort | input | 1 | Write data: abort request (set-only) |
| sw_block | input | 1 | Write data: hold queued master commands |
| abort_done | input | 1 | Master sequencer has issued STOP and flushed the transmit FIFO |
| mst_idle | input | 1 | Master state machine is idle |
| slv_idle | input | 1 | Slave state machine is idle |
| slv_rx_busy | input | 1 | Slave is receiving address or data bytes from a remote master |
| slv_rx_data | input | 1 | Addressed slave receive is in its data phase |
| tx_nempty | input | 1 | Transmit FIFO holds at least one command |
| en_bit | output | 1 | Software enable readback |
| abort_bit | output | 1 | Abort in progress; request to the master sequencer |
| block_bit | output | 1 | Command-hold readback |
| core_en | output | 1 | Internal enable and enabled status |
| fifo_flush | output | 1 | Hold both FIFOs flushed |
| disable_req | output | 1 | Disable pending: finish the transfer, NACK at the end of the byte |
| user_abort | output | 1 | One-cycle transmit-abort event with the user cause |
| cmd_start_ok | output | 1 | Master may start the queued command |
| slv_dis_busy | output | 1 | Slave disabled while busy (sticky) |
| slv_data_lost | output | 1 | Slave receive data lost (sticky) |
| mst_act | output | 1 | Master active |
| slv_act | output | 1 | Slave active |
| activity | output | 1 | Master or slave active |

## Verification
A wrong enable pipeline shows up as a core_en or fifo_flush edge one cycle early or late relative to the write. The scoreboard pins each of those edges to a single cycle. A hold term that ignores idle ends shutdown while an engine is still busy, and core_en drops in the cycle right after the disable takes effect. Faulty abort qualification, or an abort that software can clear, shows at abort_bit one cycle after the write. The slave status flags are checked both where they set and where they clear on re-enable, so a wrong set condition or a missing clear shows within three cycles of the write.

// File: rtl/i2c_enable_pkg.sv
package i2c_enable_pkg;

  // Control word written by software through the single write strobe.
  typedef struct packed {
    logic blk;
    logic abort;
    logic en;
  } ctl_word_t;

  localparam int unsigned SLV_FLAGS = 2;  // [0] disabled while busy, [1] data lost

endpackage

// File: rtl/i2cen_ctl_regs.sv
module i2cen_ctl_regs
  import i2c_enable_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  ctl_word_t wdata,
  input  logic      abort_done,
  output ctl_word_t ctl_q,
  output logic      user_abort
);

  ctl_word_t ctl_d;
  logic      evt_d, evt_q;

  always_comb begin
    ctl_d = ctl_q;
    evt_d = ctl_q.abort & abort_done;
    if (ctl_q.abort && abort_done) ctl_d.abort = 1'b0;
    if (wr) begin
      ctl_d.en  = wdata.en;
      ctl_d.blk = wdata.blk;
      // abort is set-only and qualified by the enable held before this write
      if (wdata.abort && ctl_q.en) ctl_d.abort = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      evt_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      evt_q <= evt_d;
    end
  end

  assign user_abort = evt_q;

endmodule

// File: rtl/i2cen_en_sync.sv
module i2cen_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_sw,
  input  logic all_idle,
  output logic en_sync,
  output logic core_en
);

  localparam int unsigned LEAD = (STAGES > 1) ? STAGES - 1 : 1;

  logic [LEAD-1:0] pipe_d, pipe_q;
  logic            core_d, core_q;

  generate
    if (LEAD == 1) begin : g_single
      assign pipe_d = en_sw;
    end else begin : g_chain
      assign pipe_d = {pipe_q[LEAD-2:0], en_sw};
    end
  endgenerate

  // Final stage holds high until both engines are idle.
  always_comb core_d = pipe_q[LEAD-1] | (core_q & ~all_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      core_q <= 1'b0;
    end else begin
      pipe_q <= pipe_d;
      core_q <= core_d;
    end
  end

  assign en_sync = pipe_q[LEAD-1];
  assign core_en = core_q;

endmodule

// File: rtl/i2cen_slv_status.sv
module i2cen_slv_status
  import i2c_enable_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_en,
  input  logic                 en_sync,
  input  logic                 disable_req,
  input  logic [SLV_FLAGS-1:0] cond,
  output logic [SLV_FLAGS-1:0] flags
);

  logic [SLV_FLAGS-1:0] flag_d, flag_q;
  logic                 clr;

  assign clr = ~core_en & en_sync;  // core_en rises at the coming edge

  always_comb begin
    if (clr) flag_d = '0;
    else     flag_d = flag_q | (cond & {SLV_FLAGS{disable_req}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags = flag_q;

endmodule

// File: rtl/i2c_enable_ctrl.sv
module i2c_enable_ctrl
  import i2c_enable_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_en,
  input  logic sw_abort,
  input  logic sw_block,
  input  logic abort_done,
  input  logic mst_idle,
  input  logic slv_idle,
  input  logic slv_rx_busy,
  input  logic slv_rx_data,
  input  logic tx_nempty,
  output logic en_bit,
  output logic abort_bit,
  output logic block_bit,
  output logic core_en,
  output logic fifo_flush,
  output logic disable_req,
  output logic user_abort,
  output logic cmd_start_ok,
  output logic slv_dis_busy,
  output logic slv_data_lost,
  output logic mst_act,
  output logic slv_act,
  output logic activity
);

  ctl_word_t            wdata, ctl_q;
  logic                 en_sync, core_en_i;
  logic [SLV_FLAGS-1:0] flags;
  logic                 mst_act_d, mst_act_q, slv_act_d, slv_act_q;

  assign wdata = {sw_block, sw_abort, sw_en};

  i2cen_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (sw_wr),
    .wdata      (wdata),
    .abort_done (abort_done),
    .ctl_q      (ctl_q),
    .user_abort (user_abort)
  );

  i2cen_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_sw    (ctl_q.en),
    .all_idle (mst_idle & slv_idle),
    .en_sync  (en_sync),
    .core_en  (core_en_i)
  );

  i2cen_slv_status u_slv (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_en     (core_en_i),
    .en_sync     (en_sync),
    .disable_req (disable_req),
    .cond        ({slv_rx_data, slv_rx_busy}),
    .flags       (flags)
  );

  always_comb begin
    mst_act_d = ~mst_idle;
    slv_act_d = ~slv_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_act_q <= 1'b0;
      slv_act_q <= 1'b0;
    end else begin
      mst_act_q <= mst_act_d;
      slv_act_q <= slv_act_d;
    end
  end

  assign en_bit        = ctl_q.en;
  assign abort_bit     = ctl_q.abort;
  assign block_bit     = ctl_q.blk;
  assign core_en       = core_en_i;
  assign fifo_flush    = ~en_sync;
  assign disable_req   = core_en_i & ~en_sync;
  assign cmd_start_ok  = core_en_i & en_sync & ~ctl_q.blk & tx_nempty;
  assign slv_dis_busy  = flags[0];
  assign slv_data_lost = flags[1];
  assign mst_act       = mst_act_q;
  assign slv_act       = slv_act_q;
  assign activity      = mst_act_q | slv_act_q;

endmodule

// File: rtl/i2c_enable_ctrl_chk.sv
module i2c_enable_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic abort_done,
  input logic mst_idle,
  input logic slv_idle,
  input logic slv_rx_busy,
  input logic en_bit,
  input logic abort_bit,
  input logic core_en,
  input logic fifo_flush,
  input logic disable_req,
  input logic user_abort,
  input logic cmd_start_ok,
  input logic slv_dis_busy,
  input logic slv_data_lost,
  input logic mst_act
);

  a_r2_abort_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_bit) |-> $past(en_bit));

  a_r3_abort_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    abort_bit && !abort_done |=> abort_bit);

  a_r3_abort_retire: assert property (@(posedge clk) disable iff (!rst_n)
    abort_bit && abort_done |=> user_abort);

  a_r4_rise_after_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> $past(en_bit));

  a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    core_en && !(mst_idle && slv_idle) |=> core_en);

  a_r7_busy_capture: assert property (@(posedge clk) disable iff (!rst_n)
    disable_req && slv_rx_busy |=> slv_dis_busy);

  a_r9_clear_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_en) |-> !slv_dis_busy && !slv_data_lost);

  a_r10_no_start_flushing: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start_ok |-> !fifo_flush && !disable_req);

  a_r11_master_active: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_idle |=> mst_act);

endmodule

bind i2c_enable_ctrl i2c_enable_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .abort_done    (abort_done),
  .mst_idle      (mst_idle),
  .slv_idle      (slv_idle),
  .slv_rx_busy   (slv_rx_busy),
  .en_bit        (en_bit),
  .abort_bit     (abort_bit),
  .core_en       (core_en),
  .fifo_flush    (fifo_flush),
  .disable_req   (disable_req),
  .user_abort    (user_abort),
  .cmd_start_ok  (cmd_start_ok),
  .slv_dis_busy  (slv_dis_busy),
  .slv_data_lost (slv_data_lost),
  .mst_act       (mst_act)
);

// File: tb/test_i2c_enable_ctrl.sv
module test_i2c_enable_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  logic sw_wr, sw_en, sw_abort, sw_block, abort_done;
  logic mst_idle, slv_idle, slv_rx_busy, slv_rx_data, tx_nempty;
  logic en_bit, abort_bit, block_bit, core_en, fifo_flush, disable_req;
  logic user_abort, cmd_start_ok, slv_dis_busy, slv_data_lost;
  logic mst_act, slv_act, activity;

  always #5 clk = ~clk;

  i2c_enable_ctrl i_i2c_enable_ctrl (.*);

  localparam int S_EN = 0, S_AB = 1, S_BLK = 2, S_CORE = 3, S_FL = 4, S_DREQ = 5,
                 S_UA = 6, S_GO = 7, S_DB = 8, S_DL = 9, S_MA = 10, S_SA = 11, S_ACT = 12;

  logic [12:0] obs;
  assign obs = {activity, slv_act, mst_act, slv_data_lost, slv_dis_busy, cmd_start_ok,
                user_abort, disable_req, fifo_flush, core_en, block_bit, abort_bit, en_bit};

  typedef struct {
    int   cyc;
    int   req;
    int   sel;
    logic val;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  task automatic expect_at(int d, int req, int sel, logic v);
    exp_t e;
    e.cyc = cyc + d; e.req = req; e.sel = sel; e.val = v;
    q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(logic en, logic ab, logic blk);
    sw_wr = 1'b1; sw_en = en; sw_abort = ab; sw_block = blk;
    tick();
    sw_wr = 1'b0; sw_en = 1'b0; sw_abort = 1'b0; sw_block = 1'b0;
  endtask

  // Monitor: compares scheduled expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          checks++;
          if (obs[q[i].sel] !== q[i].val) begin
            errors++;
            $display("FAIL R%0d cycle %0d signal %0d actual %b expected %b",
                     q[i].req, cyc, q[i].sel, obs[q[i].sel], q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sw_wr = 0; sw_en = 0; sw_abort = 0; sw_block = 0; abort_done = 0;
    mst_idle = 1; slv_idle = 1; slv_rx_busy = 0; slv_rx_data = 0; tx_nempty = 0;
    repeat (3) tick();
    rst_n = 1'b1;

    // R1 reset state
    expect_at(1, 1, S_EN, 0);   expect_at(1, 1, S_AB, 0);
    expect_at(1, 1, S_CORE, 0); expect_at(1, 1, S_FL, 1);
    expect_at(1, 1, S_ACT, 0);  expect_at(1, 1, S_DREQ, 0);
    expect_at(1, 1, S_DB, 0);   expect_at(1, 1, S_UA, 0);
    tick();

    // R2 abort with enable from disabled is dropped; R4 and R6 enable timing
    expect_at(1, 2, S_AB, 0);
    expect_at(1, 4, S_EN, 1);
    expect_at(2, 4, S_CORE, 0);
    expect_at(3, 4, S_CORE, 1);
    expect_at(1, 6, S_FL, 1);
    expect_at(2, 6, S_FL, 0);
    wr(1, 1, 0);
    repeat (3) tick();

    // R3 abort is set-only and retires on abort_done
    expect_at(1, 3, S_AB, 1);
    wr(1, 1, 0);
    expect_at(1, 3, S_AB, 1);
    wr(1, 0, 0);
    tick();
    expect_at(1, 3, S_AB, 0);
    expect_at(1, 3, S_UA, 1);
    expect_at(2, 3, S_UA, 0);
    abort_done = 1'b1;
    tick();
    abort_done = 1'b0;
    repeat (2) tick();

    // R10 command hold and start permission
    tx_nempty = 1'b1;
    expect_at(1, 10, S_GO, 1);
    tick();
    expect_at(1, 10, S_GO, 0);
    expect_at(1, 10, S_BLK, 1);
    wr(1, 0, 1);
    tick();
    expect_at(1, 10, S_GO, 1);
    wr(1, 0, 0);
    tick();
    tx_nempty = 1'b0;
    expect_at(1, 10, S_GO, 0);
    tick();

    // R11 activity bits
    mst_idle = 1'b0;
    expect_at(1, 11, S_MA, 1); expect_at(1, 11, S_ACT, 1); expect_at(1, 11, S_SA, 0);
    tick();
    slv_idle = 1'b0;
    expect_at(1, 11, S_SA, 1);
    tick();

    // R5 R7 R8 disable while both engines busy, slave in data phase
    slv_rx_busy = 1'b1; slv_rx_data = 1'b1;
    expect_at(2, 6, S_FL, 1);
    expect_at(2, 5, S_DREQ, 1);
    expect_at(2, 5, S_CORE, 1);
    expect_at(3, 5, S_CORE, 1);
    expect_at(3, 7, S_DB, 1);
    expect_at(3, 8, S_DL, 1);
    wr(0, 0, 0);
    repeat (3) tick();
    mst_idle = 1'b1; slv_idle = 1'b1; slv_rx_busy = 1'b0; slv_rx_data = 1'b0;
    expect_at(1, 5, S_CORE, 0);
    expect_at(1, 5, S_DREQ, 0);
    expect_at(1, 7, S_DB, 1);
    expect_at(1, 11, S_ACT, 0);
    tick();
    tick();

    // R2 abort while disabled is dropped
    expect_at(1, 2, S_AB, 0);
    wr(0, 1, 0);
    tick();

    // R9 flags clear where core_en rises
    expect_at(2, 9, S_DB, 1);
    expect_at(3, 9, S_CORE, 1);
    expect_at(3, 9, S_DB, 0);
    expect_at(3, 9, S_DL, 0);
    wr(1, 0, 0);
    repeat (3) tick();

    // R8 address phase only: no data-lost; R5 idle path drops on the second edge
    slv_rx_busy = 1'b1;
    expect_at(2, 5, S_DREQ, 1);
    expect_at(2, 5, S_CORE, 1);
    expect_at(3, 5, S_CORE, 0);
    expect_at(3, 7, S_DB, 1);
    expect_at(3, 8, S_DL, 0);
    wr(0, 0, 0);
    repeat (3) tick();
    slv_rx_busy = 1'b0;

    repeat (3) tick();
    while (q.size() != 0) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule